// File: doc/BRIEF.md
# FM Sound Timer and Interrupt Unit

This block provides the interval-timer section of a classic FM sound generator. A host writes bytes into three registers through an address/data strobe port: two timer presets and one control byte. Two up-counting timers advance on a prescaled tick-enable input. Each one raises its overflow flag when it passes full scale, unless that flag is masked. The flags and an interrupt summary bit form a readable status byte, and the summary also drives a level interrupt output.

Timer A uses a fine time base. Its 8-bit register value is multiplied by four to give a 10-bit starting count, so it can time intervals from 4 to 1024 ticks. Timer B uses a coarse time base. It steps once every 16 ticks from an 8-bit starting count. Each timer is a two-state machine. In IDLE it holds its count. The start transition IDLE->RUN happens when its run bit is set, and it loads the preset and clears the tick divider. The stop transition RUN->IDLE happens when the run bit is cleared. The overflow self-transition RUN->RUN happens on a counting step at full scale: the timer reloads its preset and pulses its overflow signal.

Top module: `fm_timer_irq`

## Requirements
- R1: After reset the status byte is 0x00 and `irq` is low.
- R2: Address 0x02 holds the timer A value V. Once started, timer A counts up by one per tick from 4*V. The tick that finds the count at 1023 sets status bit 6, which happens after 1024-4*V ticks.
- R3: Address 0x03 holds the timer B value W. Timer B counts up by one per 16 ticks from W, and it sets status bit 5 on the tick that finds its count at 255, which is after 16*(256-W) ticks.
- R4: On overflow a timer reloads its preset and keeps running, so later overflows follow at the same interval.
- R5: A write to address 0x04 with bit 7 set clears both flags and `irq`. The other bits of that write are ignored: masks and run bits keep their previous values.
- R6: In a control write with bit 7 clear, bit 6 masks timer A and bit 5 masks timer B. A masked timer never sets its flag, and setting a mask clears that flag. The other flag is unaffected.
- R7: Status bit 7 and the `irq` output are high exactly when at least one flag is set.
- R8: In a control write with bit 7 clear, bit 0 is the run bit of timer A and bit 1 is the run bit of timer B. Clearing a run bit stops that timer, which then sets no flag. Setting it again restarts the timer from its preset.
- R9: Writes to any address other than 0x02, 0x03 and 0x04 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Register data of the write |
| tick | input | 1 | Prescaled timer tick enable |
| status | output | 8 | Bit 7 interrupt, bit 6 timer A flag, bit 5 timer B flag, other bits 0 |
| irq | output | 1 | Interrupt request, high while any flag is set |

## Verification
Assertions check the following on every cycle:
- A flag rises only after an overflow pulse from its timer.
- A clear write or a set mask leaves the flag low on the next cycle.
- A timer in IDLE, or a timer not being ticked, keeps its count.
- Timer B does not move between divider wrap points.
- An overflow reloads the preset.

Only the directed scenarios can show the following:
- The exact tick counts to overflow for chosen presets.
- That the other bits of a clear write are ignored.
- That a restart reloads the preset.
- That writes to unused addresses leave the presets intact.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
    typedef enum logic {
        T_IDLE = 1'b0,
        T_RUN  = 1'b1
    } tmr_state_e;

    localparam logic [7:0] ADDR_PRESET_A = 8'h02;
    localparam logic [7:0] ADDR_PRESET_B = 8'h03;
    localparam logic [7:0] ADDR_CTRL     = 8'h04;

    localparam int CTL_CLR    = 7;
    localparam int CTL_MASK_A = 6;
    localparam int CTL_MASK_B = 5;
    localparam int CTL_RUN_B  = 1;
    localparam int CTL_RUN_A  = 0;
endpackage

// File: rtl/fmt_regs.sv
module fmt_regs
    import fmt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] preset_a_raw,
    output logic [DATA_W-1:0] preset_b,
    output logic              mask_a,
    output logic              mask_b,
    output logic              run_a,
    output logic              run_b,
    output logic              clr
);
    logic sel_a, sel_b, sel_ctl;

    always_comb begin
        sel_a   = wr_en && (wr_addr == ADDR_W'(ADDR_PRESET_A));
        sel_b   = wr_en && (wr_addr == ADDR_W'(ADDR_PRESET_B));
        sel_ctl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
        clr     = sel_ctl && wr_data[CTL_CLR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preset_a_raw <= '0;
            preset_b     <= '0;
            mask_a       <= 1'b0;
            mask_b       <= 1'b0;
            run_a        <= 1'b0;
            run_b        <= 1'b0;
        end else begin
            if (sel_a) preset_a_raw <= wr_data;
            if (sel_b) preset_b     <= wr_data;
            if (sel_ctl && !wr_data[CTL_CLR]) begin
                mask_a <= wr_data[CTL_MASK_A];
                mask_b <= wr_data[CTL_MASK_B];
                run_a  <= wr_data[CTL_RUN_A];
                run_b  <= wr_data[CTL_RUN_B];
            end
        end
    end
endmodule

// File: rtl/fmt_timer.sv
module fmt_timer
    import fmt_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int DIV_LOG2 = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic [CNT_W-1:0] preset,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam int PRE_W = (DIV_LOG2 > 0) ? DIV_LOG2 : 1;

    tmr_state_e       state, nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic [PRE_W-1:0] pre, nxt_pre;
    logic             pre_full;

    generate
        if (DIV_LOG2 > 0) begin : g_div
            assign pre_full = &pre;
        end else begin : g_nodiv
            assign pre_full = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= T_IDLE;
            cnt   <= '0;
            pre   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
            pre   <= nxt_pre;
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        nxt_pre   = pre;
        ovf       = 1'b0;
        unique case (state)
            T_IDLE: begin
                if (enable) begin
                    nxt_state = T_RUN;
                    nxt_cnt   = preset;
                    nxt_pre   = '0;
                end
            end
            T_RUN: begin
                if (!enable) begin
                    nxt_state = T_IDLE;
                end else if (tick) begin
                    nxt_pre = pre + 1'b1;
                    if (pre_full) begin
                        if (cnt == CNT_MAX) begin
                            nxt_cnt = preset;
                            ovf     = 1'b1;
                        end else begin
                            nxt_cnt = cnt + 1'b1;
                        end
                    end
                end
            end
        endcase
    end

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_IDLE && !enable) |=> $stable(cnt));
    p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_RUN && enable && !tick) |=> $stable(cnt));
    p_prescale_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_RUN && enable && tick && !pre_full) |=> $stable(cnt));
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt == $past(preset)));
endmodule

// File: rtl/fmt_flags.sv
module fmt_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_a,
    input  logic ovf_b,
    input  logic mask_a,
    input  logic mask_b,
    input  logic clr,
    output logic flag_a,
    output logic flag_b,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_a <= 1'b0;
            flag_b <= 1'b0;
        end else begin
            if (clr || mask_a)  flag_a <= 1'b0;
            else if (ovf_a)     flag_a <= 1'b1;
            if (clr || mask_b)  flag_b <= 1'b0;
            else if (ovf_b)     flag_b <= 1'b1;
        end
    end

    assign irq = flag_a | flag_b;

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!flag_a && !flag_b));
    p_mask_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_a |=> !flag_a);
    p_mask_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_b |=> !flag_b);
    p_flag_from_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_a) |-> $past(ovf_a));
endmodule

// File: rtl/fm_timer_irq.sv
module fm_timer_irq #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int A_SCALE_LOG2 = 2,
    parameter int B_DIV_LOG2  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    output logic [7:0]        status,
    output logic              irq
);
    localparam int A_W = DATA_W + A_SCALE_LOG2;

    logic [DATA_W-1:0] preset_a_raw, preset_b;
    logic [A_W-1:0]    preset_a;
    logic mask_a, mask_b, run_a, run_b, clr;
    logic ovf_a, ovf_b, flag_a, flag_b;

    assign preset_a = {preset_a_raw, {A_SCALE_LOG2{1'b0}}};

    fmt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .preset_a_raw(preset_a_raw), .preset_b(preset_b),
        .mask_a(mask_a), .mask_b(mask_b), .run_a(run_a), .run_b(run_b),
        .clr(clr)
    );

    fmt_timer #(.CNT_W(A_W), .DIV_LOG2(0)) u_tmr_a (
        .clk(clk), .rst_n(rst_n), .enable(run_a), .tick(tick),
        .preset(preset_a), .ovf(ovf_a)
    );

    fmt_timer #(.CNT_W(DATA_W), .DIV_LOG2(B_DIV_LOG2)) u_tmr_b (
        .clk(clk), .rst_n(rst_n), .enable(run_b), .tick(tick),
        .preset(preset_b), .ovf(ovf_b)
    );

    fmt_flags u_flags (
        .clk(clk), .rst_n(rst_n), .ovf_a(ovf_a), .ovf_b(ovf_b),
        .mask_a(mask_a), .mask_b(mask_b), .clr(clr),
        .flag_a(flag_a), .flag_b(flag_b), .irq(irq)
    );

    assign status = {irq, flag_a, flag_b, 5'b00000};

    p_irq_has_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(ovf_a) || $past(ovf_b)));
endmodule

// File: tb/fm_timer_irq_tb.sv
module fm_timer_irq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tick = 1'b0;
    logic [7:0] status;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fm_timer_irq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick(tick), .status(status), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] exp);
        total++;
        if (status !== exp || irq !== exp[7]) begin
            bad++;
            $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                     req, status, irq, exp, exp[7]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset", 8'h00);
    endtask

    task automatic t_timer_a();
        do_reset();
        wr(8'h02, 8'hFE);
        wr(8'h04, 8'h01);
        ticks(7);
        check("R2 A before overflow", 8'h00);
        ticks(1);
        check("R2 R7 A overflow", 8'hC0);
    endtask

    task automatic t_timer_b();
        do_reset();
        wr(8'h03, 8'hFE);
        wr(8'h04, 8'h02);
        ticks(31);
        check("R3 B before overflow", 8'h00);
        ticks(1);
        check("R3 R7 B overflow", 8'hA0);
    endtask

    task automatic t_reload();
        do_reset();
        wr(8'h02, 8'hFF);
        wr(8'h04, 8'h01);
        ticks(4);
        check("R4 first overflow", 8'hC0);
        wr(8'h04, 8'h81);
        check("R5 clear flags", 8'h00);
        ticks(3);
        check("R4 before second overflow", 8'h00);
        ticks(1);
        check("R4 second overflow", 8'hC0);
    endtask

    task automatic t_clear_ignores();
        do_reset();
        wr(8'h02, 8'hFF);
        wr(8'h04, 8'h81);
        ticks(8);
        check("R5 run bit in clear write ignored", 8'h00);
    endtask

    task automatic t_mask();
        do_reset();
        wr(8'h02, 8'hFF);
        wr(8'h04, 8'h41);
        ticks(8);
        check("R6 masked A sets no flag", 8'h00);
        wr(8'h04, 8'h01);
        ticks(4);
        check("R6 unmasked A flags", 8'hC0);
        wr(8'h04, 8'h41);
        check("R6 R7 mask clears A flag", 8'h00);
        do_reset();
        wr(8'h02, 8'hFF);
        wr(8'h03, 8'hFF);
        wr(8'h04, 8'h03);
        ticks(16);
        check("R6 both flags", 8'hE0);
        wr(8'h04, 8'h23);
        check("R6 mask B keeps A", 8'hC0);
    endtask

    task automatic t_stop();
        do_reset();
        wr(8'h02, 8'hFF);
        wr(8'h04, 8'h01);
        ticks(2);
        wr(8'h04, 8'h00);
        ticks(10);
        check("R8 stopped A sets no flag", 8'h00);
        wr(8'h04, 8'h01);
        ticks(3);
        check("R8 restart reloads preset", 8'h00);
        ticks(1);
        check("R8 restart overflow", 8'hC0);
    endtask

    task automatic t_other_addr();
        do_reset();
        wr(8'h02, 8'hFF);
        wr(8'h05, 8'hFF);
        wr(8'h42, 8'h00);
        ticks(6);
        check("R9 stray writes start nothing", 8'h00);
        wr(8'h04, 8'h01);
        ticks(3);
        check("R9 preset intact before overflow", 8'h00);
        ticks(1);
        check("R9 preset intact overflow", 8'hC0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_timer_a();
        t_timer_b();
        t_reload();
        t_clear_ignores();
        t_mask();
        t_stop();
        t_other_addr();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule